// File: doc/BRIEF.md
# Remote Access Pending-Request Cache

This block sits in the requesting cluster of a directory-coherent multiprocessor, between the local processor bus and the inbound reply network. It is a direct-mapped cache of 16-byte lines, and each entry also serves as the record of an outstanding remote request. When a local processor misses on remote memory, the request port allocates an entry and reports that a remote request must be issued. Later requests for the same line from other processors are folded onto that entry. A request that maps onto a set held by a different, still-outstanding line is told to retry.

The reply port takes data replies and invalidation acknowledgements from the network. A data reply wakes every processor waiting on the entry in one cycle. For a read, the line is then kept as valid-shared. For an exclusive request, ownership goes back to the writers at once, and the entry holds an acknowledgement count until every invalidation has been acknowledged. The per-set count is exported so that fence logic can wait on it.

The cache can also take a dirty line from a local cache and keep it as cluster-level dirty-shared, in place of a write-back. It supplies such lines, and lines brought in by prefetches, to later local requests. Replacing a dirty-shared line produces a write-back of that line in the same cycle.

Top module: `remote_pend_cache`

## Requirements
- R1: A line is the byte address with its low 4 bits dropped, because lines are 16 bytes. The set index is the low log2(SETS) bits of the line and the tag is the rest. Two addresses that differ only in bits [3:0] refer to the same line.
- R2: After reset every set is invalid and every acknowledgement count is zero. Ops are coded 0 read, 1 read-exclusive, 2 prefetch, 3 dirty deposit. Outcomes on `req_res` are coded 0 issue remote, 1 merged, 2 retry, 3 served locally. A read, exclusive or prefetch to a set that is invalid or holds a non-pending line gets outcome 0 and leaves the entry pending, except in the same-line cases of R8.
- R3: A read or prefetch to a line pending a read, or a read or exclusive to a line pending an exclusive, gets outcome 1. The requester's bit is added to the waiting mask; a prefetch adds no bit. No new remote request is made.
- R4: These requests get outcome 2 and change nothing: any request to a set pending for a different line; an exclusive or deposit to the same line pending a read; a deposit to the same line pending an exclusive; any request to a line awaiting acknowledgements; any request to the set that the reply port addresses in the same cycle.
- R5: A data reply matching a pending entry raises `rel_valid` in the same cycle. `rel_mask` equals the full waiting mask, `rel_data` equals the reply data and `rel_addr` equals the line address. A pending-read entry then becomes valid-shared and holds the reply data.
- R6: A data reply to a pending-exclusive entry carries an acknowledgement count N. If N is 0 the entry is freed. Otherwise the set's count on `ack_cnt` (field s at bits s*ACK_W upward) becomes N and the line stays held. The waiters are released at once in both cases.
- R7: Each acknowledgement to the matching entry lowers its count by one, and the entry is freed when the count reaches zero. `rsp_err` is raised in the same cycle, with no state change, for any of these: an acknowledgement to a set whose count is zero, an acknowledgement whose tag does not match, or a data reply to a line that is not pending.
- R8: A read or prefetch to a valid-shared or dirty-shared line gets outcome 3, with the line on `req_rdata`. An exclusive to a dirty-shared line gets outcome 3 and frees the entry. An exclusive to a valid-shared line gets outcome 0 and the entry becomes pending-exclusive.
- R9: A deposit (op 3) to a set that is not pending gets outcome 3 and stores `req_wdata` as dirty-shared. Later reads of that line return that data.
- R10: Any request that replaces a dirty-shared entry of a different line raises `wb_valid` in the same cycle, with that line's address and data. Replacing an invalid or valid-shared entry raises no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Bus-side request present |
| req_cpu | input | log2(NUM_CPU) | Requesting local processor |
| req_op | input | 2 | 0 read, 1 exclusive, 2 prefetch, 3 dirty deposit |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | LINE_BYTES*8 | Line data for a deposit |
| req_res | output | 2 | 0 issue, 1 merged, 2 retry, 3 served locally |
| req_rdata | output | LINE_BYTES*8 | Line data when served locally |
| wb_valid | output | 1 | Dirty-shared victim write-back |
| wb_addr | output | ADDR_W | Victim line address |
| wb_data | output | LINE_BYTES*8 | Victim line data |
| rsp_valid | input | 1 | Inbound reply present |
| rsp_kind | input | 1 | 0 data reply, 1 invalidation acknowledgement |
| rsp_addr | input | ADDR_W | Byte address of the reply |
| rsp_data | input | LINE_BYTES*8 | Reply line data |
| rsp_acks | input | ACK_W | Acknowledgements to expect (exclusive data reply) |
| rel_valid | output | 1 | Waiters released |
| rel_mask | output | NUM_CPU | Processors released |
| rel_addr | output | ADDR_W | Released line address |
| rel_data | output | LINE_BYTES*8 | Data for released processors |
| rsp_err | output | 1 | Reply did not fit any entry state |
| ack_cnt | output | SETS*ACK_W | Outstanding acknowledgement count per set |

## Verification
The bench builds the cache with 4 sets, 4 processors, 12-bit addresses and 3-bit acknowledgement counts. With so few sets, every set can be driven through a full life cycle: allocation, merging from several processors, conflict retry, read and exclusive replies, acknowledgement countdown and the error on an extra acknowledgement. Each set is also taken through deposit, dirty eviction and prefetch. Expected masks, addresses and line data come from simple arithmetic on the set number and the step.

// File: rtl/rapc_pkg.sv
// Shared encodings for the remote access pending-request cache.
package rapc_pkg;
    typedef enum logic [2:0] {
        ST_INV = 3'd0,   // no line
        ST_PRD = 3'd1,   // read or prefetch outstanding
        ST_PEX = 3'd2,   // exclusive request outstanding
        ST_ACK = 3'd3,   // ownership granted, acknowledgements outstanding
        ST_VSH = 3'd4,   // clean copy held
        ST_DSH = 3'd5    // cluster dirty-shared copy held
    } ent_state_t;

    typedef enum logic [1:0] {
        OP_READ = 2'd0, OP_EXCL = 2'd1, OP_PREF = 2'd2, OP_DEPOSIT = 2'd3
    } req_op_t;

    typedef enum logic [1:0] {
        RES_ISSUE = 2'd0, RES_MERGE = 2'd1, RES_RETRY = 2'd2, RES_HIT = 2'd3
    } req_res_t;

    typedef enum logic {
        RSP_DATA = 1'b0, RSP_ACK = 1'b1
    } rsp_kind_t;
endpackage

// File: rtl/rapc_req_ctl.sv
// Request-side decision for one addressed set.
// Decides issue, merge, retry or local service for a bus request, and
// gives the entry's next state and waiting mask. Assumes the caller blocks
// requests to a set the reply port is updating in the same cycle.
module rapc_req_ctl
    import rapc_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int CPU_W   = 2,
    parameter int TAG_W   = 8
) (
    input  logic               valid,
    input  logic               blocked,
    input  logic [CPU_W-1:0]   cpu,
    input  req_op_t            op,
    input  logic [TAG_W-1:0]   tag,
    input  ent_state_t         cur_st,
    input  logic [TAG_W-1:0]   cur_tag,
    input  logic [NUM_CPU-1:0] cur_wait,
    output req_res_t           res,
    output logic               upd,
    output ent_state_t         nxt_st,
    output logic [NUM_CPU-1:0] nxt_wait,
    output logic               load_data,
    output logic               evict
);
    logic [NUM_CPU-1:0] me;
    logic               same;
    logic               busy;

    // Requester bit, tag hit and pending flag for the addressed set.
    always_comb begin
        me   = {{(NUM_CPU-1){1'b0}}, 1'b1} << cpu;
        same = (cur_tag == tag) && (cur_st != ST_INV);
        busy = (cur_st == ST_PRD) || (cur_st == ST_PEX) || (cur_st == ST_ACK);
    end

    // Outcome and next entry contents for the request.
    always_comb begin
        res       = RES_RETRY;
        upd       = 1'b0;
        nxt_st    = cur_st;
        nxt_wait  = cur_wait;
        load_data = 1'b0;
        evict     = 1'b0;
        if (valid && !blocked) begin
            if (busy) begin
                if (same && ((cur_st == ST_PRD && (op == OP_READ || op == OP_PREF)) ||
                             (cur_st == ST_PEX && op != OP_DEPOSIT))) begin
                    res      = RES_MERGE;
                    upd      = 1'b1;
                    nxt_wait = cur_wait | ((op == OP_PREF) ? '0 : me);
                end
            end else if (same) begin
                case (op)
                    OP_READ, OP_PREF: res = RES_HIT;
                    OP_EXCL: begin
                        upd = 1'b1;
                        if (cur_st == ST_DSH) begin
                            res      = RES_HIT;
                            nxt_st   = ST_INV;
                            nxt_wait = '0;
                        end else begin
                            res      = RES_ISSUE;
                            nxt_st   = ST_PEX;
                            nxt_wait = me;
                        end
                    end
                    default: begin
                        res       = RES_HIT;
                        upd       = 1'b1;
                        nxt_st    = ST_DSH;
                        load_data = 1'b1;
                    end
                endcase
            end else begin
                evict    = (cur_st == ST_DSH);
                upd      = 1'b1;
                nxt_wait = '0;
                case (op)
                    OP_READ: begin res = RES_ISSUE; nxt_st = ST_PRD; nxt_wait = me; end
                    OP_PREF: begin res = RES_ISSUE; nxt_st = ST_PRD; end
                    OP_EXCL: begin res = RES_ISSUE; nxt_st = ST_PEX; nxt_wait = me; end
                    default: begin res = RES_HIT; nxt_st = ST_DSH; load_data = 1'b1; end
                endcase
            end
        end
    end
endmodule

// File: rtl/rapc_rsp_ctl.sv
// Reply-side decision for one addressed set.
// Applies a data reply or an invalidation acknowledgement to the entry,
// releases waiters on data and flags replies that fit no pending state.
// Assumes acknowledgements only arrive after the exclusive data reply.
module rapc_rsp_ctl
    import rapc_pkg::*;
#(
    parameter int TAG_W = 8,
    parameter int ACK_W = 4
) (
    input  logic             valid,
    input  rsp_kind_t        kind,
    input  logic [TAG_W-1:0] tag,
    input  logic [ACK_W-1:0] acks_in,
    input  ent_state_t       cur_st,
    input  logic [TAG_W-1:0] cur_tag,
    input  logic [ACK_W-1:0] cur_acks,
    output logic             upd,
    output ent_state_t       nxt_st,
    output logic [ACK_W-1:0] nxt_acks,
    output logic             load_data,
    output logic             release_w,
    output logic             err
);
    logic match;

    // Next entry state, release and error for the reply.
    always_comb begin
        match     = (cur_tag == tag);
        upd       = 1'b0;
        nxt_st    = cur_st;
        nxt_acks  = cur_acks;
        load_data = 1'b0;
        release_w = 1'b0;
        err       = 1'b0;
        if (valid) begin
            if (kind == RSP_DATA) begin
                if (match && cur_st == ST_PRD) begin
                    upd       = 1'b1;
                    release_w = 1'b1;
                    load_data = 1'b1;
                    nxt_st    = ST_VSH;
                end else if (match && cur_st == ST_PEX) begin
                    upd       = 1'b1;
                    release_w = 1'b1;
                    nxt_acks  = acks_in;
                    nxt_st    = (acks_in == '0) ? ST_INV : ST_ACK;
                end else begin
                    err = 1'b1;
                end
            end else begin
                if (match && cur_st == ST_ACK && cur_acks != '0) begin
                    upd      = 1'b1;
                    nxt_acks = cur_acks - 1'b1;
                    if (cur_acks == {{(ACK_W-1){1'b0}}, 1'b1}) nxt_st = ST_INV;
                end else begin
                    err = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/remote_pend_cache.sv
// Remote access pending-request cache, direct-mapped, one entry per set.
// Request port answers in the same cycle; state commits on the clock edge.
// The reply port wins a set both ports address in one cycle (request retried).
module remote_pend_cache
    import rapc_pkg::*;
#(
    parameter int NUM_CPU    = 4,
    parameter int SETS       = 32,
    parameter int ADDR_W     = 28,
    parameter int ACK_W      = 4,
    parameter int LINE_BYTES = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [$clog2(NUM_CPU)-1:0] req_cpu,
    input  logic [1:0]                 req_op,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [LINE_BYTES*8-1:0]    req_wdata,
    output logic [1:0]                 req_res,
    output logic [LINE_BYTES*8-1:0]    req_rdata,
    output logic                       wb_valid,
    output logic [ADDR_W-1:0]          wb_addr,
    output logic [LINE_BYTES*8-1:0]    wb_data,
    input  logic                       rsp_valid,
    input  logic                       rsp_kind,
    input  logic [ADDR_W-1:0]          rsp_addr,
    input  logic [LINE_BYTES*8-1:0]    rsp_data,
    input  logic [ACK_W-1:0]           rsp_acks,
    output logic                       rel_valid,
    output logic [NUM_CPU-1:0]         rel_mask,
    output logic [ADDR_W-1:0]          rel_addr,
    output logic [LINE_BYTES*8-1:0]    rel_data,
    output logic                       rsp_err,
    output logic [SETS*ACK_W-1:0]      ack_cnt
);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
    localparam int CPU_W  = $clog2(NUM_CPU);
    localparam int DATA_W = LINE_BYTES * 8;

    ent_state_t         st [SETS];
    logic [TAG_W-1:0]   tg [SETS];
    logic [NUM_CPU-1:0] wt [SETS];
    logic [ACK_W-1:0]   ac [SETS];
    logic [DATA_W-1:0]  dt [SETS];

    logic [IDX_W-1:0] q_idx, r_idx;
    logic [TAG_W-1:0] q_tag, r_tag;
    logic             unused_offsets;

    // Split both addresses into tag and set index.
    always_comb begin
        q_idx = req_addr[OFF_W +: IDX_W];
        q_tag = req_addr[ADDR_W-1 -: TAG_W];
        r_idx = rsp_addr[OFF_W +: IDX_W];
        r_tag = rsp_addr[ADDR_W-1 -: TAG_W];
    end
    assign unused_offsets = ^{req_addr[OFF_W-1:0], rsp_addr[OFF_W-1:0]};

    req_res_t           q_res;
    logic               q_upd, q_load, q_evict;
    ent_state_t         q_nxt_st;
    logic [NUM_CPU-1:0] q_nxt_wait;

    rapc_req_ctl #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W), .TAG_W(TAG_W)) u_req (
        .valid    (req_valid),
        .blocked  (rsp_valid && (r_idx == q_idx)),
        .cpu      (req_cpu),
        .op       (req_op_t'(req_op)),
        .tag      (q_tag),
        .cur_st   (st[q_idx]),
        .cur_tag  (tg[q_idx]),
        .cur_wait (wt[q_idx]),
        .res      (q_res),
        .upd      (q_upd),
        .nxt_st   (q_nxt_st),
        .nxt_wait (q_nxt_wait),
        .load_data(q_load),
        .evict    (q_evict)
    );

    logic             r_upd, r_load, r_rel, r_err;
    ent_state_t       r_nxt_st;
    logic [ACK_W-1:0] r_nxt_acks;

    rapc_rsp_ctl #(.TAG_W(TAG_W), .ACK_W(ACK_W)) u_rsp (
        .valid    (rsp_valid),
        .kind     (rsp_kind_t'(rsp_kind)),
        .tag      (r_tag),
        .acks_in  (rsp_acks),
        .cur_st   (st[r_idx]),
        .cur_tag  (tg[r_idx]),
        .cur_acks (ac[r_idx]),
        .upd      (r_upd),
        .nxt_st   (r_nxt_st),
        .nxt_acks (r_nxt_acks),
        .load_data(r_load),
        .release_w(r_rel),
        .err      (r_err)
    );

    // Entry storage: reply updates and request updates never share a set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SETS; i++) begin
                st[i] <= ST_INV;
                tg[i] <= '0;
                wt[i] <= '0;
                ac[i] <= '0;
                dt[i] <= '0;
            end
        end else begin
            if (r_upd) begin
                st[r_idx] <= r_nxt_st;
                wt[r_idx] <= '0;
                ac[r_idx] <= r_nxt_acks;
                if (r_load) dt[r_idx] <= rsp_data;
            end
            if (q_upd) begin
                st[q_idx] <= q_nxt_st;
                tg[q_idx] <= q_tag;
                wt[q_idx] <= q_nxt_wait;
                ac[q_idx] <= '0;
                if (q_load) dt[q_idx] <= req_wdata;
            end
        end
    end

    // Request-side outputs: outcome, local data and victim write-back.
    always_comb begin
        req_res   = q_res;
        req_rdata = dt[q_idx];
        wb_valid  = q_evict;
        wb_addr   = {tg[q_idx], q_idx, {OFF_W{1'b0}}};
        wb_data   = dt[q_idx];
    end

    // Reply-side outputs: release of waiters and error flag.
    always_comb begin
        rel_valid = r_rel;
        rel_mask  = r_rel ? wt[r_idx] : '0;
        rel_addr  = {rsp_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        rel_data  = rsp_data;
        rsp_err   = r_err;
    end

    // Per-set acknowledgement counts flattened for the fence logic.
    for (genvar g = 0; g < SETS; g++) begin : g_ack
        assign ack_cnt[g*ACK_W +: ACK_W] = ac[g];
    end
endmodule

// File: rtl/rapc_checker.sv
// Protocol checker for the pending-request cache, attached by bind.
// Watches only the ports of the cache.
module rapc_checker #(
    parameter int NUM_CPU    = 4,
    parameter int SETS       = 32,
    parameter int ADDR_W     = 28,
    parameter int ACK_W      = 4,
    parameter int LINE_BYTES = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic [ADDR_W-1:0]     req_addr,
    input logic [1:0]            req_res,
    input logic                  wb_valid,
    input logic                  rsp_valid,
    input logic                  rsp_kind,
    input logic [ADDR_W-1:0]     rsp_addr,
    input logic                  rel_valid,
    input logic                  rsp_err,
    input logic [SETS*ACK_W-1:0] ack_cnt
);
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int IDX_W = $clog2(SETS);

    logic [IDX_W-1:0] q_idx, r_idx, r_idx_q;
    logic [ACK_W-1:0] cnt_now, cnt_q;
    logic             unused_chk;

    assign q_idx      = req_addr[OFF_W +: IDX_W];
    assign r_idx      = rsp_addr[OFF_W +: IDX_W];
    assign cnt_now    = ack_cnt[r_idx*ACK_W +: ACK_W];
    assign unused_chk = ^{req_addr, rsp_addr, NUM_CPU[0]};

    // Remember the replied set and its count for the next-cycle check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_idx_q <= '0;
            cnt_q   <= '0;
        end else begin
            r_idx_q <= r_idx;
            cnt_q   <= cnt_now;
        end
    end

    p_conflict_retry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rsp_valid && q_idx == r_idx) |-> req_res == 2'd2)
        else $error("same-set request not retried");

    p_wb_on_alloc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (req_valid && (req_res == 2'd0 || req_res == 2'd3)))
        else $error("write-back without allocation");

    p_rel_from_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid |-> (rsp_valid && !rsp_kind && !rsp_err))
        else $error("release without a good data reply");

    p_ack_zero_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind && cnt_now == '0) |-> rsp_err)
        else $error("acknowledgement on zero count accepted");

    p_ack_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind && !rsp_err) |=>
            ack_cnt[r_idx_q*ACK_W +: ACK_W] == cnt_q - 1'b1)
        else $error("acknowledgement count not decremented");

    p_acks_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |=> ack_cnt == $past(ack_cnt))
        else $error("count changed without a reply");
endmodule

bind remote_pend_cache rapc_checker #(
    .NUM_CPU(NUM_CPU), .SETS(SETS), .ADDR_W(ADDR_W), .ACK_W(ACK_W), .LINE_BYTES(LINE_BYTES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_res(req_res), .wb_valid(wb_valid), .rsp_valid(rsp_valid),
    .rsp_kind(rsp_kind), .rsp_addr(rsp_addr), .rel_valid(rel_valid),
    .rsp_err(rsp_err), .ack_cnt(ack_cnt)
);

// File: tb/remote_pend_cache_test.sv
// Self-checking bench: walks every set of a 4-set cache through its life cycle.
module remote_pend_cache_test;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_CPU = 4, SETS = 4, ADDR_W = 12, ACK_W = 3, LB = 16;
    localparam int DW = LB * 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 0, rsp_valid = 0, rsp_kind = 0;
    logic [1:0] req_cpu = 0, req_op = 0;
    logic [ADDR_W-1:0] req_addr = 0, rsp_addr = 0;
    logic [DW-1:0] req_wdata = 0, rsp_data = 0;
    logic [ACK_W-1:0] rsp_acks = 0;
    logic [1:0] req_res;
    logic [DW-1:0] req_rdata, wb_data, rel_data;
    logic wb_valid, rel_valid, rsp_err;
    logic [ADDR_W-1:0] wb_addr, rel_addr;
    logic [NUM_CPU-1:0] rel_mask;
    logic [SETS*ACK_W-1:0] ack_cnt;

    remote_pend_cache #(.NUM_CPU(NUM_CPU), .SETS(SETS), .ADDR_W(ADDR_W),
                        .ACK_W(ACK_W), .LINE_BYTES(LB)) uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0, n_err = 0;
    logic [1:0] g_res;
    logic [DW-1:0] g_rdata, g_wbd, g_reld;
    logic g_wb, g_rel, g_err;
    logic [ADDR_W-1:0] g_wba, g_rela;
    logic [NUM_CPU-1:0] g_mask;

    localparam int ISSUE = 0, MERGE = 1, RETRY = 2, HIT = 3;
    localparam int RD = 0, EX = 1, PF = 2, DP = 3;

    function automatic logic [ADDR_W-1:0] mk(int t, int s, int off);
        return ADDR_W'((t << 6) | (s << 4) | off);
    endfunction

    function automatic logic [DW-1:0] dv(int s, int k);
        return {32'(k), 32'(s), 32'hC0DE_0000 + 32'(k), 32'(s * k + 7)};
    endfunction

    task automatic check(input string what, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %0h expected %0h", what, got, exp);
        end
    endtask

    // Drive one cycle on both ports, capture same-cycle outputs.
    task automatic cyc(input bit qv, input int cpu, input int op, input logic [ADDR_W-1:0] qa,
                       input logic [DW-1:0] qd, input bit pv, input bit pk,
                       input logic [ADDR_W-1:0] pa, input logic [DW-1:0] pd, input int acks);
        @(negedge clk);
        req_valid = qv; req_cpu = 2'(cpu); req_op = 2'(op); req_addr = qa; req_wdata = qd;
        rsp_valid = pv; rsp_kind = pk; rsp_addr = pa; rsp_data = pd; rsp_acks = ACK_W'(acks);
        #1;
        g_res = req_res; g_rdata = req_rdata; g_wb = wb_valid; g_wba = wb_addr; g_wbd = wb_data;
        g_rel = rel_valid; g_mask = rel_mask; g_rela = rel_addr; g_reld = rel_data; g_err = rsp_err;
    endtask

    task automatic rq(input int cpu, input int op, input logic [ADDR_W-1:0] a, input logic [DW-1:0] d);
        cyc(1, cpu, op, a, d, 0, 0, '0, '0, 0);
    endtask

    task automatic rs(input bit k, input logic [ADDR_W-1:0] a, input logic [DW-1:0] d, input int acks);
        cyc(0, 0, 0, '0, '0, 1, k, a, d, acks);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 0; rsp_valid = 0;
        #1;
    endtask

    function automatic logic [ACK_W-1:0] cnt(int s);
        return ack_cnt[s*ACK_W +: ACK_W];
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        check("R2 reset ack counts", DW'(ack_cnt), '0);
        check("R2 reset no release", DW'(rel_valid), 0);
        check("R2 reset no error", DW'(rsp_err), 0);
        for (int s = 0; s < SETS; s++) begin
            automatic int ta = s + 1, tb = s + 9;
            automatic logic [ADDR_W-1:0] a = mk(ta, s, 0), b = mk(tb, s, 0);
            rq(0, RD, a, '0);               check("R2 first read issues", DW'(g_res), ISSUE);
            check("R10 no wb from invalid", DW'(g_wb), 0);
            rq(1, RD, mk(ta, s, 7), '0);    check("R1 same line other offset merges", DW'(g_res), MERGE);
            rq(2, PF, mk(ta, s, 15), '0);   check("R3 prefetch merges", DW'(g_res), MERGE);
            rq(3, RD, b, '0);               check("R4 conflict retries", DW'(g_res), RETRY);
            rq(3, EX, a, '0);               check("R4 exclusive on pending read retries", DW'(g_res), RETRY);
            cyc(1, 3, RD, b, '0, 1, 0, mk(ta, s, 3), dv(s, 1), 0);
            check("R4 reply-port set priority", DW'(g_res), RETRY);
            check("R5 release valid", DW'(g_rel), 1);
            check("R5 release mask", DW'(g_mask), 4'b0011);
            check("R5 release addr", DW'(g_rela), DW'(a));
            check("R5 release data", g_reld, dv(s, 1));
            rq(3, RD, a, '0);               check("R8 read hit", DW'(g_res), HIT);
            check("R5 stored data", g_rdata, dv(s, 1));
            rq(3, EX, a, '0);               check("R8 upgrade issues", DW'(g_res), ISSUE);
            rq(2, EX, a, '0);               check("R3 exclusive merge", DW'(g_res), MERGE);
            rq(1, RD, a, '0);               check("R3 read onto exclusive merge", DW'(g_res), MERGE);
            rs(0, a, dv(s, 2), 2);
            check("R6 early release", DW'(g_rel), 1);
            check("R6 release mask", DW'(g_mask), 4'b1110);
            idle();                         check("R6 ack count loaded", DW'(cnt(s)), 2);
            rq(0, RD, a, '0);               check("R4 awaiting acks retries", DW'(g_res), RETRY);
            rs(1, a, '0, 0);                check("R7 ack accepted", DW'(g_err), 0);
            idle();                         check("R7 count decremented", DW'(cnt(s)), 1);
            rs(1, a, '0, 0);
            idle();                         check("R7 count zero", DW'(cnt(s)), 0);
            rs(1, a, '0, 0);                check("R7 extra ack error", DW'(g_err), 1);
            rq(0, RD, b, '0);               check("R7 freed entry reissues", DW'(g_res), ISSUE);
            rs(0, b, dv(s, 3), 0);          check("R5 mask single", DW'(g_mask), 4'b0001);
            rq(1, DP, a, dv(s, 4));         check("R9 deposit accepted", DW'(g_res), HIT);
            check("R10 clean victim no wb", DW'(g_wb), 0);
            rq(2, RD, mk(ta, s, 9), '0);    check("R9 deposit read hit", DW'(g_res), HIT);
            check("R9 deposit data", g_rdata, dv(s, 4));
            rq(3, DP, b, dv(s, 5));         check("R10 dirty victim wb", DW'(g_wb), 1);
            check("R10 wb addr", DW'(g_wba), DW'(a));
            check("R10 wb data", g_wbd, dv(s, 4));
            rq(0, EX, b, '0);               check("R8 exclusive dirty hit", DW'(g_res), HIT);
            check("R8 exclusive dirty data", g_rdata, dv(s, 5));
            rq(0, PF, b, '0);               check("R8 freed after exclusive", DW'(g_res), ISSUE);
            rs(0, b, dv(s, 6), 0);          check("R5 prefetch release", DW'(g_rel), 1);
            check("R5 prefetch no waiters", DW'(g_mask), 0);
            rq(1, EX, a, '0);               check("R2 exclusive issue", DW'(g_res), ISSUE);
            check("R10 clean prefetch victim", DW'(g_wb), 0);
            rs(0, a, dv(s, 7), 0);          check("R6 zero-ack release", DW'(g_mask), 4'b0010);
            idle();                         check("R6 zero-ack count", DW'(cnt(s)), 0);
            rq(1, RD, a, '0);               check("R6 zero-ack frees", DW'(g_res), ISSUE);
            rq(2, DP, a, dv(s, 8));         check("R4 deposit on pending retries", DW'(g_res), RETRY);
            rs(0, b, dv(s, 9), 0);          check("R7 tag mismatch error", DW'(g_err), 1);
            check("R7 mismatch no release", DW'(g_rel), 0);
            rs(0, a, dv(s, 10), 0);         check("R5 final release", DW'(g_mask), 4'b0010);
            idle();
        end
        for (int s = 0; s < SETS; s++) begin
            rq(s, RD, mk(s + 1, s, 0), '0);
            check("R1 sets independent", g_rdata, dv(s, 10));
        end
        idle();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule